// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Change Interrupts

This block is a bank of up to 32 general-purpose I/O lines, controlled through four 32-bit registers on a simple word-addressed bus. A single-cycle strobe carries each access. Each line has a direction bit and an output value bit. The bank drives `pin_out` and `pin_oe` from these registers and samples `pin_in` through a synchroniser.

Every synchronised line feeds a change detector that reacts to both edges. Any rising or falling transition sets a sticky bit in the change register. Software clears that bit by writing a 1 to it. A separate enable register masks each line. The single `irq` output is high while any change bit that is set also has its enable bit set.

Reads return data on `bus_rdata` one cycle after the read strobe. The read value then holds until the next read.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads as zero, `pin_oe` and `pin_out` are zero, and `irq` is low.
- R2: A write to word 0 (the direction register) sets `pin_oe`. A 1 in bit n makes line n an output and a 0 makes it an input. Word 0 reads back the stored value.
- R3: A write to word 1 (the data register) sets `pin_out`. A read of word 1 returns the stored output bit for output lines and the synchronised `pin_in` level for input lines.
- R4: A write to word 2 (the enable register) stores the per-line enable bits, and word 2 reads back the stored value.
- R5: Both a rising and a falling transition on `pin_in[n]` set bit n of word 3 (the change register). Following a pin change, the bit reads 1 after the third rising clock edge, and it stays set.
- R6: Writing word 3 clears each change bit that has a 1 in the write data. Change bits with a 0 in the write data are unchanged.
- R7: When a new edge and a clearing write reach the same change bit in the same cycle, the bit stays set.
- R8: `irq` equals the OR over all lines of (change bit AND enable bit), registered one cycle after the change register. It therefore rises at the fourth rising edge after a pin change on an enabled line.
- R9: Bits at and above `LINES` read as zero in every register, and writes to them are ignored.
- R10: Word addresses 4 and above read as zero. Writes to them change no register and no pin.
- R11: An output value written while a line is still an input appears on `pin_out` at once. The pin therefore drives that level in the same cycle that `pin_oe` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pin_in | input | LINES | Pad input levels (asynchronous) |
| pin_out | output | LINES | Output values |
| pin_oe | output | LINES | Output enables |
| irq | output | 1 | Combined change interrupt |

## Verification
The assertions assume that bus strobes last exactly one clock and that `pin_in` is stable around reset. They also assume a pin toggles at most once per synchroniser latency, so that consecutive edges on one line are never merged. The stimulus keeps `pin_in` at zero through reset, drives all bus signals at falling edges for one cycle, and waits several cycles after each pin change. The single deliberate overlap is the directed case that aligns a clearing write with a fresh edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_EN   = 2'd2,
    SEL_CHG  = 2'd3
  } reg_sel_t;

  localparam int NUM_REGS = 4;

  function automatic logic is_mapped(input logic [31:0] word);
    return word < NUM_REGS;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) st[s] <= '0;
        else     st[s] <= st[s-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_change.sv
module gpio_change #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] clr,
  output logic [W-1:0] chg
);
  logic [W-1:0] level_d;
  logic [W-1:0] edge_v;
  logic [W-1:0] chg_q;

  assign edge_v = level ^ level_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d <= '0;
      chg_q   <= '0;
    end else begin
      level_d <= level;
      chg_q   <= (chg_q & ~clr) | edge_v;
    end
  end

  assign chg = chg_q;

  // R5
  edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|edge_v) |=> (($past(edge_v) & ~chg_q) == '0));

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((chg_q & ~$past(chg_q) & ~$past(edge_v)) == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(chg_q) & ~$past(clr)) & ~chg_q) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int LINES       = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe,
  output logic              irq
);
  logic [LINES-1:0] dir_q, dat_q, en_q;
  logic [LINES-1:0] pin_s, chg, clr;
  logic [BUS_W-1:0] rd_next;
  logic             mapped, wr, rd;
  reg_sel_t         sel;

  assign mapped = is_mapped(32'(bus_addr));
  assign sel    = reg_sel_t'(bus_addr[1:0]);
  assign wr     = bus_sel & bus_we & mapped;
  assign rd     = bus_sel & ~bus_we;

  gpio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  assign clr = (wr && sel == SEL_CHG) ? bus_wdata[LINES-1:0] : '0;

  gpio_change #(.W(LINES)) u_change (
    .clk   (clk),
    .rst   (rst),
    .level (pin_s),
    .clr   (clr),
    .chg   (chg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      dat_q <= '0;
      en_q  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DIR:  dir_q <= bus_wdata[LINES-1:0];
        SEL_DATA: dat_q <= bus_wdata[LINES-1:0];
        SEL_EN:   en_q  <= bus_wdata[LINES-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    if (mapped) begin
      case (sel)
        SEL_DIR:  rd_next[LINES-1:0] = dir_q;
        SEL_DATA: rd_next[LINES-1:0] = (dir_q & dat_q) | (~dir_q & pin_s);
        SEL_EN:   rd_next[LINES-1:0] = en_q;
        SEL_CHG:  rd_next[LINES-1:0] = chg;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd) bus_rdata <= rd_next;
      irq <= |(chg & en_q);
    end
  end

  assign pin_out = dat_q;
  assign pin_oe  = dir_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq && pin_oe == '0 && pin_out == '0 && bus_rdata == '0));

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(chg & en_q)) |=> irq);

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(chg & en_q)) |=> !irq);

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_DIR) |=> $stable(pin_oe));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_DATA) |=> $stable(pin_out));

  generate
    if (LINES < BUS_W) begin : g_upper
      // R9
      upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[BUS_W-1:LINES] == '0);
    end
  endgenerate
endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int PERIOD = 10;
  localparam int LINES  = 12;
  localparam int AW     = 4;
  localparam logic [31:0] MASK = 32'((64'd1 << LINES) - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [LINES-1:0] pin_in = '0;
  logic [LINES-1:0] pin_out, pin_oe;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_dir = 0, m_dat = 0, m_en = 0, m_chg = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_bank #(.LINES(LINES), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = AW'(w); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input int w, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = AW'(w);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_pins(input logic [LINES-1:0] v);
    @(negedge clk);
    m_chg = (m_chg | 32'(pin_in ^ v)) & MASK;
    pin_in = v;
    settle();
  endtask

  function automatic logic [31:0] exp_data();
    return ((m_dir & m_dat) | (~m_dir & 32'(pin_in))) & MASK;
  endfunction

  task automatic check_all();
    logic [31:0] r;
    rd(0, r); check("R2", r, m_dir);
    rd(1, r); check("R3", r, exp_data());
    rd(2, r); check("R4", r, m_en);
    rd(3, r); check("R5", r, m_chg);
    check("R8", 32'(irq), 32'(|(m_chg & m_en)));
    check("R2 pins", 32'(pin_oe), m_dir);
    check("R3 pins", 32'(pin_out), m_dat);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 oe", 32'(pin_oe), 0);
    check("R1 out", 32'(pin_out), 0);
    for (int w = 0; w < 4; w++) begin
      rd(w, r); check("R1 reg", r, 0);
    end

    // R9 upper bits ignored
    wr(0, 32'hFFFF_FFFF); m_dir = MASK;
    wr(2, 32'hFFFF_FFFF); m_en = MASK;
    rd(0, r); check("R9 dir", r, MASK);
    rd(2, r); check("R9 en", r, MASK);
    wr(0, 0); m_dir = 0;

    // R11 data written before direction
    wr(1, 32'h8); m_dat = 32'h8;
    check("R11 out pre", 32'(pin_out[3]), 1);
    check("R11 oe pre", 32'(pin_oe[3]), 0);
    wr(0, 32'h8); m_dir = 32'h8;
    check("R11 oe", 32'(pin_oe[3]), 1);
    check("R11 out", 32'(pin_out[3]), 1);

    // R5 / R8 exact latency on rising edge of line 0
    @(negedge clk); pin_in[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 not yet", 32'(irq), 0);
    @(posedge clk); @(negedge clk);
    check("R8 latency", 32'(irq), 1);
    m_chg = 32'h1;
    rd(3, r); check("R5 rise", r, 32'h1);
    // R6 clear with mixed mask
    wr(3, 32'hFFE); rd(3, r); check("R6 keep", r, 32'h1);
    wr(3, 32'h1); m_chg = 0;
    rd(3, r); check("R6 clear", r, 0);
    repeat (2) @(negedge clk);
    check("R8 drop", 32'(irq), 0);
    // R5 falling edge
    set_pins('0);
    rd(3, r); check("R5 fall", r, 32'h1);

    // R7 edge and clear in same cycle on line 0 (bit already set)
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = AW'(3); bus_wdata = 32'h1;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    settle();
    rd(3, r); check("R7 edge wins", r, 32'h1);
    m_chg = 32'h1;

    // R10 unmapped words
    for (int w = 4; w < 16; w++) begin
      wr(w, 32'hFFFF_FFFF);
      rd(w, r); check("R10 read", r, 0);
    end
    check_all();

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] v;
      v = $urandom;
      case ($urandom % 6)
        0: begin wr(0, v); m_dir = v & MASK; end
        1: begin wr(1, v); m_dat = v & MASK; end
        2: begin wr(2, v); m_en  = v & MASK; end
        3: begin wr(3, v); m_chg = m_chg & ~v; settle(); end
        4: set_pins(LINES'(v));
        default: begin
          wr(4 + ($urandom % 12), v);
          rd(4 + ($urandom % 12), r); check("R10 rand", r, 0);
        end
      endcase
      check_all();
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule